// File: doc/BRIEF.md
# SPI Prescaled Timing Sequencer

This block paces one SPI frame for a shift engine. A single start pulse, together with a 24-bit attribute word, launches a fixed series of phases. Chip select asserts first. A lead-in delay follows, then a set number of SCK periods, then a trailing delay. Chip select then releases, unless the frame was marked as continuing. An idle gap closes the frame. Each duration is the product of a small prescaler and a scaler, both decoded from fields of the attribute word. The baud scaler uses an irregular table. The three delay scalers are powers of two.

The block drives no data. It gives the shift engine single-cycle strobes: one where SCK is about to rise, one where it is about to fall, and one at the end of each delay phase. The attribute word, the frame length and the continue flag are captured at start. Changes to those inputs during a frame do not affect it.

Top module: `spi_phase_timer`

## Requirements
- R1: After reset, cs_o, sck_o, busy_o and all five strobes are 0.
- R2: A start_i pulse seen while idle asserts cs_o and busy_o from the next cycle. The lead-in phase lasts L cycles and pre_done_o is high in its last cycle. L = {1,3,5,7}[attr_i[23:22]] × 2^(attr_i[15:12]+1).
- R3: The SCK period is P = {2,3,5,7}[attr_i[17:16]] × S system clocks. S, indexed by attr_i[3:0], is 2,4,6,8 for codes 0–3 and 2^code for codes 4–15. Every period has a low half of P/2 cycles followed by a high half of P/2 cycles.
- R4: lead_o pulses in the last low cycle of each period and trail_o in the last high cycle. A frame has exactly nbits_i periods, and a length of 0 behaves as 1.
- R5: The trailing phase starts after the last high half. It lasts {1,3,5,7}[attr_i[21:20]] × 2^(attr_i[11:8]+1) cycles, with post_done_o high in its last cycle.
- R6: The gap phase follows. It lasts {1,3,5,7}[attr_i[19:18]] × 2^(attr_i[7:4]+1) cycles, with gap_done_o high in its last cycle. busy_o is 0 from the next cycle.
- R7: cs_o stays 1 from the lead-in through the trailing phase. From the gap onward, cs_o equals the cont_i value captured at start, and it keeps that value while idle.
- R8: start_i is ignored while busy_o is 1. attr_i, nbits_i and cont_i are sampled only with the accepted start.
- R9: The five strobes are single-cycle pulses, and no two of them are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame launch pulse |
| attr_i | input | 24 | Prescaler and scaler fields for SCK and the three delays |
| nbits_i | input | NB_W | Number of SCK periods in the frame |
| cont_i | input | 1 | Keep chip select asserted after the frame |
| cs_o | output | 1 | Chip select active (1 = asserted) |
| sck_o | output | 1 | Serial clock, idle low |
| pre_done_o | output | 1 | Last cycle of the lead-in delay |
| lead_o | output | 1 | Last low cycle of an SCK period |
| trail_o | output | 1 | Last high cycle of an SCK period |
| post_done_o | output | 1 | Last cycle of the trailing delay |
| gap_done_o | output | 1 | Last cycle of the idle gap |
| busy_o | output | 1 | Frame in progress |

## Verification
The assertions check several rules on every cycle:
- the strobes never overlap;
- SCK is never high without chip select;
- every lead strobe is followed by a high SCK and every trail strobe by a low SCK;
- busy holds until the gap ends;
- the phase counter steps down by exactly one.

Only the bench scenarios show that the decoded durations are right. The bench measures them in cycles for many field combinations, including the largest baud scaler code, a zero frame length and both continue settings. The same applies to capture at start: a stray start and changed inputs mid-frame are shown to leave the timing unchanged.

// File: rtl/spt_pkg.sv
package spt_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_LOW,
        PH_HIGH,
        PH_TRAIL,
        PH_GAP
    } phase_e;

    // baud prescaler: 2,3,5,7
    function automatic logic [31:0] baud_pre(input logic [1:0] code);
        case (code)
            2'd0:    baud_pre = 32'd2;
            2'd1:    baud_pre = 32'd3;
            2'd2:    baud_pre = 32'd5;
            default: baud_pre = 32'd7;
        endcase
    endfunction

    // baud scaler: 2,4,6,8 then powers of two
    function automatic logic [31:0] baud_scl(input logic [3:0] code);
        if (code < 4'd4)
            baud_scl = 32'd2 * ({28'd0, code} + 32'd1);
        else
            baud_scl = 32'd1 << code;
    endfunction

    // delay prescaler: 1,3,5,7
    function automatic logic [31:0] dly_pre(input logic [1:0] code);
        dly_pre = 32'd2 * {30'd0, code} + 32'd1;
    endfunction

    // delay length: prescaler times 2^(code+1)
    function automatic logic [31:0] dly_len(input logic [1:0] p, input logic [3:0] s);
        dly_len = dly_pre(p) << ({28'd0, s} + 32'd1);
    endfunction

endpackage

// File: rtl/spt_len_decode.sv
module spt_len_decode #(
    parameter int CNT_W = 20
) (
    input  logic [23:0]      attr_i,
    output logic [CNT_W-1:0] lead_len_o,
    output logic [CNT_W-1:0] half_len_o,
    output logic [CNT_W-1:0] trail_len_o,
    output logic [CNT_W-1:0] gap_len_o
);
    import spt_pkg::*;

    logic [31:0] lead_w, half_w, trail_w, gap_w;

    always_comb begin
        lead_w  = dly_len(attr_i[23:22], attr_i[15:12]);
        trail_w = dly_len(attr_i[21:20], attr_i[11:8]);
        gap_w   = dly_len(attr_i[19:18], attr_i[7:4]);
        // every scaler entry is even, so half a period is exact
        half_w  = baud_pre(attr_i[17:16]) * (baud_scl(attr_i[3:0]) >> 1);
    end

    assign lead_len_o  = lead_w[CNT_W-1:0];
    assign half_len_o  = half_w[CNT_W-1:0];
    assign trail_len_o = trail_w[CNT_W-1:0];
    assign gap_len_o   = gap_w[CNT_W-1:0];

endmodule

// File: rtl/spt_down_ctr.sv
module spt_down_ctr #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] cnt_o,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);

    // phase durations rely on a strict one-per-cycle step (R2)
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !zero_o) |=> (cnt_o == W'($past(cnt_o) - 1'b1)));

    assert_zero_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && zero_o) |=> zero_o);

endmodule

// File: rtl/spi_phase_timer.sv
module spi_phase_timer #(
    parameter int CNT_W = 20,
    parameter int NB_W  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [23:0]     attr_i,
    input  logic [NB_W-1:0] nbits_i,
    input  logic            cont_i,
    output logic            cs_o,
    output logic            sck_o,
    output logic            pre_done_o,
    output logic            lead_o,
    output logic            trail_o,
    output logic            post_done_o,
    output logic            gap_done_o,
    output logic            busy_o
);
    import spt_pkg::*;

    typedef struct packed {
        phase_e          st;
        logic            cs;
        logic            cont;
        logic [23:0]     attr;
        logic [NB_W-1:0] left;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             zero;
    logic [CNT_W-1:0] cnt;
    logic [23:0]      dec_src;
    logic [CNT_W-1:0] lead_len, half_len, trail_len, gap_len;

    // while idle the live attribute sizes the lead-in; afterwards the captured one
    assign dec_src = (ctl_q.st == PH_IDLE) ? attr_i : ctl_q.attr;

    spt_len_decode #(.CNT_W(CNT_W)) u_dec (
        .attr_i      (dec_src),
        .lead_len_o  (lead_len),
        .half_len_o  (half_len),
        .trail_len_o (trail_len),
        .gap_len_o   (gap_len)
    );

    spt_down_ctr #(.W(CNT_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ld),
        .val_i  (ld_val),
        .cnt_o  (cnt),
        .zero_o (zero)
    );

    always_comb begin
        ctl_d  = ctl_q;
        ld     = 1'b0;
        ld_val = '0;
        case (ctl_q.st)
            PH_IDLE: if (start_i) begin
                ctl_d.st   = PH_LEAD;
                ctl_d.cs   = 1'b1;
                ctl_d.cont = cont_i;
                ctl_d.attr = attr_i;
                ctl_d.left = nbits_i;
                ld         = 1'b1;
                ld_val     = lead_len - 1'b1;
            end
            PH_LEAD: if (zero) begin
                ctl_d.st = PH_LOW;
                ld       = 1'b1;
                ld_val   = half_len - 1'b1;
            end
            PH_LOW: if (zero) begin
                ctl_d.st = PH_HIGH;
                ld       = 1'b1;
                ld_val   = half_len - 1'b1;
            end
            PH_HIGH: if (zero) begin
                ld = 1'b1;
                if (ctl_q.left <= NB_W'(1)) begin
                    ctl_d.st = PH_TRAIL;
                    ld_val   = trail_len - 1'b1;
                end else begin
                    ctl_d.st   = PH_LOW;
                    ctl_d.left = ctl_q.left - 1'b1;
                    ld_val     = half_len - 1'b1;
                end
            end
            PH_TRAIL: if (zero) begin
                ctl_d.st = PH_GAP;
                ctl_d.cs = ctl_q.cont;
                ld       = 1'b1;
                ld_val   = gap_len - 1'b1;
            end
            PH_GAP: if (zero) begin
                ctl_d.st = PH_IDLE;
            end
            default: ctl_d.st = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st   <= PH_IDLE;
            ctl_q.cs   <= 1'b0;
            ctl_q.cont <= 1'b0;
            ctl_q.attr <= '0;
            ctl_q.left <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cs_o        = ctl_q.cs;
    assign sck_o       = (ctl_q.st == PH_HIGH);
    assign busy_o      = (ctl_q.st != PH_IDLE);
    assign pre_done_o  = (ctl_q.st == PH_LEAD)  && zero;
    assign lead_o      = (ctl_q.st == PH_LOW)   && zero;
    assign trail_o     = (ctl_q.st == PH_HIGH)  && zero;
    assign post_done_o = (ctl_q.st == PH_TRAIL) && zero;
    assign gap_done_o  = (ctl_q.st == PH_GAP)   && zero;

    assert_strobes_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pre_done_o, lead_o, trail_o, post_done_o, gap_done_o}));

    assert_sck_under_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> cs_o);

    assert_lead_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lead_o |=> sck_o);

    assert_trail_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trail_o |=> !sck_o);

    assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(gap_done_o));

    assert_frame_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !gap_done_o) |=> busy_o);

endmodule

// File: tb/sim_spi_phase_timer.sv
module sim_spi_phase_timer;

    localparam int NB_W = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [23:0]     attr_i = '0;
    logic [NB_W-1:0] nbits_i = '0;
    logic            cont_i = 1'b0;
    logic cs_o, sck_o, pre_done_o, lead_o, trail_o, post_done_o, gap_done_o, busy_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    spi_phase_timer #(.CNT_W(20), .NB_W(NB_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .attr_i(attr_i),
        .nbits_i(nbits_i), .cont_i(cont_i), .cs_o(cs_o), .sck_o(sck_o),
        .pre_done_o(pre_done_o), .lead_o(lead_o), .trail_o(trail_o),
        .post_done_o(post_done_o), .gap_done_o(gap_done_o), .busy_o(busy_o)
    );

    // attr = {lead pre, trail pre, gap pre, baud pre, lead scl, trail scl, gap scl, baud scl}
    localparam int NV = 7;
    localparam int V_ATTR [NV] = '{
        {2'd0, 2'd1, 2'd0, 2'd0, 4'd0, 4'd0, 4'd1, 4'd0},
        {2'd2, 2'd0, 2'd3, 2'd1, 4'd1, 4'd2, 4'd0, 4'd1},
        {2'd3, 2'd2, 2'd1, 2'd3, 4'd0, 4'd1, 4'd2, 4'd2},
        {2'd1, 2'd3, 2'd2, 2'd2, 4'd3, 4'd0, 4'd0, 4'd3},
        {2'd0, 2'd0, 2'd0, 2'd0, 4'd0, 4'd0, 4'd0, 4'd4},
        {2'd0, 2'd0, 2'd0, 2'd1, 4'd0, 4'd0, 4'd0, 4'd5},
        {2'd1, 2'd1, 2'd1, 2'd0, 4'd0, 4'd0, 4'd0, 4'd0}
    };
    localparam int V_N    [NV] = '{3, 2, 1, 2, 1, 1, 0};
    localparam int V_CONT [NV] = '{0, 1, 0, 0, 1, 0, 1};
    localparam int E_N    [NV] = '{3, 2, 1, 2, 1, 1, 1};
    localparam int E_PRE  [NV] = '{2, 20, 14, 48, 2, 2, 6};
    localparam int E_PER  [NV] = '{4, 12, 42, 40, 32, 96, 4};
    localparam int E_AFT  [NV] = '{6, 8, 20, 14, 2, 2, 6};
    localparam int E_GAP  [NV] = '{4, 14, 24, 10, 2, 2, 6};

    task automatic chk(input bit ok, input string req, input string tag,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, tag, act, exp);
        end
    endtask

    task automatic run_frame(input logic [23:0] attr, input int n, input bit cont,
                             input int en, input int e_pre, input int e_per,
                             input int e_aft, input int e_gap, input bit poke,
                             input string tag);
        int idx = 0;
        int pre_at = -1, first_lead = -1, lead_cnt = 0, last_trail = -1;
        int post_at = -1, gap_at = -1, hi_cnt = 0, multi = 0, s;
        bit cs_bad = 0, gcs_bad = 0, done = 0;
        @(negedge clk);
        attr_i = attr; nbits_i = n[NB_W-1:0]; cont_i = cont; start_i = 1'b1;
        while (!done && idx < 100000) begin
            @(negedge clk);
            idx++;
            start_i = 1'b0;
            if (poke && idx == 3) begin
                start_i = 1'b1; attr_i = '1; nbits_i = '1; cont_i = ~cont;
            end
            s = int'(pre_done_o) + int'(lead_o) + int'(trail_o) + int'(post_done_o) + int'(gap_done_o);
            if (s > 1) multi++;
            if (sck_o) hi_cnt++;
            if (post_at < 0 && !cs_o) cs_bad = 1;
            if (post_at >= 0 && cs_o != cont) gcs_bad = 1;
            if (pre_done_o && pre_at < 0) pre_at = idx;
            if (lead_o) begin lead_cnt++; if (first_lead < 0) first_lead = idx; end
            if (trail_o) last_trail = idx;
            if (post_done_o && post_at < 0) post_at = idx;
            if (gap_done_o) begin gap_at = idx; done = 1; end
        end
        chk(pre_at == e_pre, "R2 lead-in", tag, pre_at, e_pre);
        chk(first_lead == e_pre + e_per/2, "R3 low half", tag, first_lead, e_pre + e_per/2);
        chk(hi_cnt == en * (e_per/2), "R3 high cycles", tag, hi_cnt, en * (e_per/2));
        chk(lead_cnt == en, "R4 period count", tag, lead_cnt, en);
        chk(last_trail == e_pre + en*e_per, "R4 last trail", tag, last_trail, e_pre + en*e_per);
        chk(post_at == last_trail + e_aft, "R5 trailing delay", tag, post_at, last_trail + e_aft);
        chk(gap_at == post_at + e_gap, "R6 gap", tag, gap_at, post_at + e_gap);
        chk(!cs_bad, "R7 cs held", tag, int'(cs_bad), 0);
        chk(!gcs_bad, "R7 cs in gap", tag, int'(gcs_bad), 0);
        chk(multi == 0, "R9 strobe overlap", tag, multi, 0);
        @(negedge clk);
        chk(!busy_o, "R6 busy drop", tag, int'(busy_o), 0);
        chk(cs_o == cont, "R7 idle cs", tag, int'(cs_o), int'(cont));
    endtask

    initial begin
        #(8 * 195000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!cs_o && !sck_o && !busy_o, "R1 reset outputs", "reset", int'({cs_o, sck_o, busy_o}), 0);
        chk(!(pre_done_o | lead_o | trail_o | post_done_o | gap_done_o),
            "R1 reset strobes", "reset", 1, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!cs_o && !busy_o, "R1 after release", "reset", int'({cs_o, busy_o}), 0);

        for (int v = 0; v < NV; v++)
            run_frame(24'(V_ATTR[v]), V_N[v], V_CONT[v] != 0, E_N[v], E_PRE[v],
                      E_PER[v], E_AFT[v], E_GAP[v], 1'b0, $sformatf("vec%0d", v));

        // R8: start and input changes during a frame have no effect
        run_frame(24'(V_ATTR[1]), V_N[1], 1'b0, E_N[1], E_PRE[1], E_PER[1],
                  E_AFT[1], E_GAP[1], 1'b1, "poke");

        // R3: top baud scaler code 15 -> 2*32768
        run_frame({2'd0, 2'd0, 2'd0, 2'd0, 4'd0, 4'd0, 4'd0, 4'd15}, 1, 1'b0, 1,
                  2, 65536, 2, 2, 1'b0, "max_baud");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule